// File: doc/BRIEF.md
# Load Align and Extend Unit

This combinational unit sits between the data-memory read port and the register write-back of a little-endian core. Memory returns two adjacent, naturally aligned 64-bit words: the one that holds the first byte of the access and the one after it. The unit uses the low three address bits to pick the requested bytes out of the 16 bytes of these two words. It then widens the value to register width, either copying the top loaded bit (sign extension) or filling with zeros.

Loads need not be aligned. An access of any size may start at any of the eight byte offsets. When the access runs past the end of the first word, the remaining bytes come from the low end of the second word, and a flag tells the memory side that the second word was needed. Size and signedness combinations that the configured register width does not support are flagged as illegal, and the data output is then forced to zero.

Top module: `ldx_load_align`

## Requirements
- R1: The byte order is little-endian. Byte i of the loaded value is the memory byte at byte offset `byte_off + i`, and offset 0 of `word_lo` is its bits [7:0].
- R2: The encoding of `acc_size` is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Every size works at every offset from 0 to 7. Bytes at offsets 8 and above are taken from `word_hi`, with offset 8 being `word_hi[7:0]`.
- R3: When `zero_ext` is 0, loads narrower than the register fill every bit above the loaded value with the value's most significant bit.
- R4: When `zero_ext` is 1, loads narrower than 64 bits fill every bit above the loaded value with zero.
- R5: With XLEN = 64, a signed 8-byte load returns the eight selected bytes unchanged.
- R6: `illegal` is 1 for an 8-byte load with `zero_ext` = 1. When XLEN = 32 it is also 1 for any 8-byte load and for a 4-byte load with `zero_ext` = 1. In every other case it is 0. While `illegal` is 1, `rdata` is zero.
- R7: `crosses` is 1 exactly when `byte_off` plus the access size in bytes is greater than 8. This holds for illegal requests as well.
- R8: With XLEN = 32, `rdata` is 32 bits wide. A signed 4-byte load returns the four selected bytes unchanged, and 1- and 2-byte loads are extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_lo | input | 64 | Aligned memory word that holds the first byte of the access |
| word_hi | input | 64 | The next aligned memory word |
| byte_off | input | 3 | Low address bits: the starting byte offset within `word_lo` |
| acc_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| zero_ext | input | 1 | 1 = zero-extend, 0 = sign-extend |
| rdata | output | XLEN | Aligned and extended register value |
| illegal | output | 1 | The size and signedness combination is not valid for XLEN |
| crosses | output | 1 | The access needs bytes from `word_hi` |

## Verification
Every combination of offset, size and extension mode is swept over several word-pair patterns, and each result is compared with a value the bench assembles byte by byte.

Each pattern separates a different class of fault:
- An ascending byte-index pattern exposes byte-order and lane-selection mistakes.
- Patterns of 0x80 and 0x7F bytes, and of all-ones, decide whether the extension reads the sign bit from the correct position.
- Irregular constants catch lanes that are swapped but hold equal values.

A second instance with 32-bit registers covers the reduced output width and the extra illegal cases. Directed cases cover a half-word split across the two words and a fully aligned double.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
    localparam int WORD_W   = 64;
    localparam int WORD_B   = WORD_W / 8;
    localparam int OFF_W    = $clog2(WORD_B);
    localparam int N_SIZES  = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    function automatic logic [OFF_W:0] size_bytes(input acc_size_e sz);
        return (OFF_W+1)'(1) << sz;
    endfunction
endpackage

// File: rtl/ldx_window.sv
module ldx_window
    import ldx_pkg::*;
(
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    input  logic [OFF_W-1:0]  off,
    output logic [WORD_W-1:0] raw
);
    localparam int WIN_W = 2 * WORD_W;

    logic [WIN_W-1:0] window;
    assign window = {hi, lo};

    for (genvar j = 0; j < WORD_B; j++) begin : g_lane
        logic [OFF_W:0] idx;
        always_comb begin
            idx = {1'b0, off} + (OFF_W+1)'(j);
            raw[8*j +: 8] = window[8*idx +: 8];
        end
    end
endmodule

// File: rtl/ldx_extend.sv
module ldx_extend
    import ldx_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  acc_size_e         size,
    input  logic              zero_ext,
    output logic [WORD_W-1:0] ext
);
    logic [WORD_W-1:0] cand [N_SIZES];

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        localparam int VW = 8 << s;
        if (VW >= WORD_W) begin : g_full
            assign cand[s] = raw;
        end else begin : g_part
            logic fill;
            assign fill    = zero_ext ? 1'b0 : raw[VW-1];
            assign cand[s] = {{(WORD_W-VW){fill}}, raw[VW-1:0]};
        end
    end

    assign ext = cand[size];
endmodule

// File: rtl/ldx_legal.sv
module ldx_legal
    import ldx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  acc_size_e        size,
    input  logic             zero_ext,
    input  logic [OFF_W-1:0] off,
    output logic             illegal,
    output logic             crosses
);
    localparam bit NARROW = (XLEN < WORD_W);

    logic [OFF_W:0] end_pos;

    always_comb begin
        end_pos = {1'b0, off} + size_bytes(size);
        crosses = end_pos > (OFF_W+1)'(WORD_B);
        illegal = (size == SZ_DBL) && zero_ext;
        if (NARROW) begin
            illegal = illegal || (size == SZ_DBL) || ((size == SZ_WORD) && zero_ext);
        end
    end
endmodule

// File: rtl/ldx_load_align.sv
module ldx_load_align
    import ldx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [63:0]      word_lo,
    input  logic [63:0]      word_hi,
    input  logic [2:0]       byte_off,
    input  logic [1:0]       acc_size,
    input  logic             zero_ext,
    output logic [XLEN-1:0]  rdata,
    output logic             illegal,
    output logic             crosses
);
    typedef struct packed {
        logic [XLEN-1:0] data;
        logic            illegal;
        logic            crosses;
    } ld_out_t;

    acc_size_e         size;
    logic [WORD_W-1:0] raw;
    logic [WORD_W-1:0] ext;
    logic              ill_w;
    logic              crs_w;
    ld_out_t           out_d;

    assign size = acc_size_e'(acc_size);

    ldx_window u_window (
        .lo  (word_lo),
        .hi  (word_hi),
        .off (byte_off),
        .raw (raw)
    );

    ldx_extend u_extend (
        .raw      (raw),
        .size     (size),
        .zero_ext (zero_ext),
        .ext      (ext)
    );

    ldx_legal #(.XLEN(XLEN)) u_legal (
        .size     (size),
        .zero_ext (zero_ext),
        .off      (byte_off),
        .illegal  (ill_w),
        .crosses  (crs_w)
    );

    always_comb begin
        out_d         = '0;
        out_d.illegal = ill_w;
        out_d.crosses = crs_w;
        out_d.data    = ill_w ? '0 : ext[XLEN-1:0];
    end

    assign rdata   = out_d.data;
    assign illegal = out_d.illegal;
    assign crosses = out_d.crosses;
endmodule

// File: rtl/ldx_load_align_chk.sv
module ldx_load_align_chk #(
    parameter int XLEN = 64
) (
    input logic [63:0]     word_lo,
    input logic [2:0]      byte_off,
    input logic [1:0]      acc_size,
    input logic            zero_ext,
    input logic [XLEN-1:0] rdata,
    input logic            illegal,
    input logic            crosses
);
    always_comb begin
        if (illegal) begin
            AST_ILLEGAL_ZERO: assert (rdata == '0); // R6
        end
        if (acc_size == 2'd3 && zero_ext) begin
            AST_UDBL_ILLEGAL: assert (illegal); // R6
        end
        if (crosses) begin
            AST_CROSS_NEEDS_OFFSET: assert (byte_off != 3'd0 && acc_size != 2'd0); // R7
        end
        if (acc_size == 2'd3 && byte_off != 3'd0) begin
            AST_DBL_UNALIGNED_CROSS: assert (crosses); // R7
        end
        if (acc_size == 2'd0 && zero_ext && !illegal) begin
            AST_BYTE_ZERO_FILL: assert (rdata[XLEN-1:8] == '0); // R4
        end
        if (acc_size == 2'd0 && !zero_ext) begin
            AST_BYTE_SIGN_FILL: assert (rdata[XLEN-1:8] == {(XLEN-8){rdata[7]}}); // R3
        end
        if (byte_off == 3'd0 && !illegal) begin
            AST_LE_LOW_BYTE: assert (rdata[7:0] == word_lo[7:0]); // R1
        end
    end
endmodule

bind ldx_load_align ldx_load_align_chk #(.XLEN(XLEN)) u_chk (
    .word_lo  (word_lo),
    .byte_off (byte_off),
    .acc_size (acc_size),
    .zero_ext (zero_ext),
    .rdata    (rdata),
    .illegal  (illegal),
    .crosses  (crosses)
);

// File: tb/ldx_load_align_tb.sv
module ldx_load_align_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [63:0] lo, hi;
    logic [2:0]  off;
    logic [1:0]  sz;
    logic        zx;
    logic [63:0] r64;
    logic [31:0] r32;
    logic        ill64, cr64, ill32, cr32;

    int checks = 0;
    int fails  = 0;

    ldx_load_align #(.XLEN(64)) u_dut (
        .word_lo(lo), .word_hi(hi), .byte_off(off), .acc_size(sz), .zero_ext(zx),
        .rdata(r64), .illegal(ill64), .crosses(cr64)
    );

    ldx_load_align #(.XLEN(32)) u_dut32 (
        .word_lo(lo), .word_hi(hi), .byte_off(off), .acc_size(sz), .zero_ext(zx),
        .rdata(r32), .illegal(ill32), .crosses(cr32)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s off=%0d sz=%0d zx=%0d actual=%h expected=%h",
                     req, off, sz, zx, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [63:0] wl, input logic [63:0] wh,
                                          input int o, input int s, input logic z);
        logic [127:0] w;
        logic [63:0]  v;
        int n;
        w = {wh, wl};
        v = '0;
        n = 1 << s;
        for (int i = 0; i < n; i++) v[8*i +: 8] = w[8*(o+i) +: 8];
        if (!z && n < 8) begin
            for (int b = 8*n; b < 64; b++) v[b] = v[8*n-1];
        end
        return v;
    endfunction

    task automatic apply(input logic [63:0] a, input logic [63:0] b,
                         input int o, input int s, input logic z);
        @(negedge clk);
        lo = a; hi = b; off = 3'(o); sz = 2'(s); zx = z;
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] plo, phi, e;
        logic        e_ill64, e_ill32, e_cr;
        string       tag;
        int          n;

        // Idle state: all inputs zero gives a zero result, no flags
        apply(64'h0, 64'h0, 0, 0, 1'b0);
        chk("R1 idle data", r64, 64'h0);
        chk("R7 idle cross", {63'h0, cr64}, 64'h0);
        chk("R6 idle illegal", {63'h0, ill64}, 64'h0);

        // R1 aligned double keeps byte order
        apply(64'h0706050403020100, 64'h0, 0, 3, 1'b0);
        chk("R1 aligned dbl", r64, 64'h0706050403020100);
        // R2 half split across the two words
        apply(64'hAA00000000000000, 64'h0000000000000055, 7, 1, 1'b1);
        chk("R2 split half", r64, 64'h00000000000055AA);
        chk("R7 split half cross", {63'h0, cr64}, 64'h1);
        // R3 signed split half
        apply(64'h8000000000000000, 64'h00000000000000F1, 7, 1, 1'b0);
        chk("R3 split half sign", r64, 64'hFFFFFFFFFFFFF180);

        for (int k = 0; k < 6; k++) begin
            case (k)
                0: begin plo = 64'h0706050403020100; phi = 64'h0F0E0D0C0B0A0908; end
                1: begin plo = '1;                   phi = '1;                   end
                2: begin plo = 64'h8080808080808080; phi = 64'h7F7F7F7F7F7F7F7F; end
                3: begin plo = 64'h7F7F7F7F7F7F7F7F; phi = 64'h8080808080808080; end
                4: begin plo = 64'hDEADBEEF0123F00D; phi = 64'h89ABCDEFFEDCBA98; end
                default: begin plo = 64'h00FF00FF807F017E; phi = 64'hC3A55A3C96690FF0; end
            endcase
            for (int o = 0; o < 8; o++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int z = 0; z < 2; z++) begin
                        apply(plo, phi, o, s, z[0]);
                        n       = 1 << s;
                        e_ill64 = (s == 3) && z[0];
                        e_ill32 = (s == 3) || ((s == 2) && z[0]);
                        e_cr    = (o + n) > 8;
                        e = e_ill64 ? 64'h0 : model(plo, phi, o, s, z[0]);
                        if (e_ill64)       tag = "R6 data";
                        else if (n == 8)   tag = "R5 dbl";
                        else if (e_cr)     tag = "R2 crossing";
                        else if (z[0])     tag = "R4 zero ext";
                        else               tag = "R3 sign ext";
                        chk(tag, r64, e);
                        chk("R6 flag64", {63'h0, ill64}, {63'h0, e_ill64});
                        chk("R7 cross64", {63'h0, cr64}, {63'h0, e_cr});
                        e = e_ill32 ? 64'h0 : {32'h0, model(plo, phi, o, s, z[0]) & 64'hFFFFFFFF};
                        chk("R8 data32", {32'h0, r32}, e);
                        chk("R6 flag32", {63'h0, ill32}, {63'h0, e_ill32});
                        chk("R7 cross32", {63'h0, cr32}, {63'h0, e_cr});
                    end
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule